// File: doc/BRIEF.md
# Memory Scrubber Control State Sequencer

This block is the control core of a configuration-memory scrubbing monitor. After reset it runs a short start-up phase and then watches for error detections from a scan engine outside the block. Decoded single-letter commands from a command port park it in a quiet state, send it back to watching, or ask it to corrupt one chosen bit on purpose for testing. A detection that arrives while it is watching walks it through a repair phase and a grading phase, and then it returns to watching by itself.

Each state has a fixed one-hot code. The current code is always visible, and every change of state raises a one-cycle event that carries the new code for a report formatter. The correctability and essential flags are sticky. Each of them is rewritten only at its own point in the repair chain, and the formatter gets a flag-change event each time. An injection command carries a 40-bit linear address. The block splits it into frame, word and bit, and raises a one-cycle request to a memory port outside the block.

Top module: `scrub_seq`

## Requirements
- R1: `cur_state` holds one of these codes: 8'h00 idle, 8'h01 start-up, 8'h02 watching, 8'h04 repair, 8'h08 grading, 8'h10 injection. `st_onehot[4:0]` equals `cur_state[4:0]`: bit 0 start-up, bit 1 watching, bit 2 repair, bit 3 grading, bit 4 injection.
- R2: Reset puts the block in start-up. The first clock edge after reset is released raises a state-change event with code 8'h01. The block moves to watching on its own at the INIT_CYCLES-th edge after reset is released.
- R3: Command 8'h49 ('I') moves the block from watching to idle at the next edge. Command 8'h4F ('O') moves it from idle to watching at the next edge.
- R4: In idle, `st_onehot` is all zero, and `st_uncorr` and `st_essential` keep the values they had before idle.
- R5: In idle, command 8'h4E ('N') with a valid address moves the block into injection for INJ_CYCLES cycles, with `st_onehot[4]` high. It then returns to idle.
- R6: The injection address layout is: bits [39:36] must be 4'hC, bits [35:12] are the frame, bits [11:5] are the word and bits [4:0] are the bit. A word of 93 or more, or any other tag, makes 'N' ignored. `inj_req` pulses for one cycle on entry to injection and carries the fields. For example, 40'hC0000007A0 gives frame 0, word 61, bit 0.
- R7: `det_valid` while watching moves the block to repair for CORR_CYCLES cycles, then to grading for CLSF_CYCLES cycles, then back to watching. A detection in any other state is ignored. When a detection and a command arrive in the same cycle, the detection wins.
- R8: On the edge that leaves repair, `fc_evt` pulses and `st_uncorr` becomes the inverse of `det_correctable` as sampled with the detection. `fc_code` is {1'b0, essential, uncorrectable, 5'b0}.
- R9: On the edge that leaves grading, `fc_evt` pulses and `st_essential` becomes 1. A correctable error therefore reports `fc_code` 8'h40.
- R10: A command that is not valid in the current state, or an unknown code, changes nothing. Commands are never acted on in start-up, repair, grading or injection.
- R11: Every state change pulses `sc_evt` for one cycle, with `sc_code` equal to the new code. No change of state means no `sc_evt`, apart from the start-up event of R2.
- R12: Both flags are 0 after reset. Each flag holds its value until its own update point comes round again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command letter (ASCII) |
| cmd_addr | input | 40 | Linear address for injection |
| det_valid | input | 1 | Error detection from the scan engine |
| det_correctable | input | 1 | Detected error can be repaired |
| cur_state | output | 8 | Current state code |
| st_onehot | output | 5 | One-hot status per active state |
| st_uncorr | output | 1 | Sticky uncorrectable flag |
| st_essential | output | 1 | Sticky essential flag |
| sc_evt | output | 1 | State-change event |
| sc_code | output | 8 | New state code for the event |
| fc_evt | output | 1 | Flag-change event |
| fc_code | output | 8 | Flag value for the event |
| inj_req | output | 1 | Bit-flip request pulse |
| inj_frame | output | 24 | Frame to corrupt |
| inj_word | output | 7 | Word within the frame |
| inj_bit | output | 5 | Bit within the word |

## Verification
Every command or detection takes effect on the first edge that samples it. The new state, its event and any injection request are visible right after that edge. A timed state lasts exactly its parameter count of edges. Each flag moves on the same edge that leaves its phase. The bench drives inputs on the falling edge and holds them for one cycle. It compares every output on each falling edge against a behavioural model that advances on the rising edge, so any result that is one cycle early or late is caught.

// File: rtl/scrub_seq_pkg.sv
package scrub_seq_pkg;

    typedef enum logic [7:0] {
        ST_IDLE = 8'h00,
        ST_INIT = 8'h01,
        ST_OBSV = 8'h02,
        ST_CORR = 8'h04,
        ST_CLSF = 8'h08,
        ST_INJT = 8'h10
    } scrub_state_e;

    localparam int NUM_CMDS = 3;
    // Decoder slot order: 0 = park, 1 = resume watching, 2 = inject
    localparam logic [7:0] CMD_TABLE [NUM_CMDS] = '{8'h49, 8'h4F, 8'h4E};

    localparam int CMD_SLOT_IDLE = 0;
    localparam int CMD_SLOT_OBSV = 1;
    localparam int CMD_SLOT_INJT = 2;

    localparam logic [3:0] ADDR_TAG = 4'hC;

endpackage

// File: rtl/scrub_cmd_decode.sv
module scrub_cmd_decode
    import scrub_seq_pkg::*;
(
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_code,
    output logic [NUM_CMDS-1:0] cmd_hit
);

    for (genvar g = 0; g < NUM_CMDS; g++) begin : g_slot
        assign cmd_hit[g] = cmd_valid && (cmd_code == CMD_TABLE[g]);
    end

endmodule

// File: rtl/scrub_addr_split.sv
module scrub_addr_split
    import scrub_seq_pkg::*;
#(
    parameter int ADDR_W          = 40,
    parameter int WORDS_PER_FRAME = 93,
    parameter int DATA_W          = 32,
    localparam int BIT_W   = $clog2(DATA_W),
    localparam int WORD_W  = $clog2(WORDS_PER_FRAME),
    localparam int TAG_W   = 4,
    localparam int FRAME_W = ADDR_W - TAG_W - WORD_W - BIT_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [FRAME_W-1:0] frame,
    output logic [WORD_W-1:0]  word,
    output logic [BIT_W-1:0]   bit_idx,
    output logic               addr_ok
);

    localparam logic [WORD_W-1:0] WORD_LIMIT = WORD_W'(WORDS_PER_FRAME);

    logic [TAG_W-1:0] tag;

    always_comb begin
        bit_idx = addr[BIT_W-1:0];
        word    = addr[BIT_W +: WORD_W];
        frame   = addr[BIT_W+WORD_W +: FRAME_W];
        tag     = addr[ADDR_W-1 -: TAG_W];
        addr_ok = (tag == ADDR_TAG) && (word < WORD_LIMIT);
    end

endmodule

// File: rtl/scrub_flag_track.sv
module scrub_flag_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       corr_done,
    input  logic       corr_ok,
    input  logic       clsf_done,
    output logic       st_uncorr,
    output logic       st_essential,
    output logic       fc_evt,
    output logic [7:0] fc_code
);

    typedef struct packed {
        logic unc;
        logic ess;
        logic evt;
    } flag_s;

    flag_s flag_d, flag_q;

    always_comb begin
        flag_d     = flag_q;
        flag_d.evt = 1'b0;
        if (corr_done) begin
            flag_d.unc = ~corr_ok;
            flag_d.evt = 1'b1;
        end
        if (clsf_done) begin
            flag_d.ess = 1'b1;
            flag_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign st_uncorr    = flag_q.unc;
    assign st_essential = flag_q.ess;
    assign fc_evt       = flag_q.evt;
    assign fc_code      = {1'b0, flag_q.ess, flag_q.unc, 5'b0};

endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm
    import scrub_seq_pkg::*;
#(
    parameter int INIT_CYCLES = 4,
    parameter int CORR_CYCLES = 3,
    parameter int CLSF_CYCLES = 2,
    parameter int INJ_CYCLES  = 2,
    parameter int FRAME_W     = 24,
    parameter int WORD_W      = 7,
    parameter int BIT_W       = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CMDS-1:0] cmd_hit,
    input  logic                addr_ok,
    input  logic [FRAME_W-1:0]  addr_frame,
    input  logic [WORD_W-1:0]   addr_word,
    input  logic [BIT_W-1:0]    addr_bit,
    input  logic                det_valid,
    input  logic                det_correctable,
    output logic [7:0]          cur_state,
    output logic                sc_evt,
    output logic [7:0]          sc_code,
    output logic                inj_req,
    output logic [FRAME_W-1:0]  inj_frame,
    output logic [WORD_W-1:0]   inj_word,
    output logic [BIT_W-1:0]    inj_bit,
    output logic                corr_done,
    output logic                clsf_done,
    output logic                corr_ok
);

    localparam int MAX_A   = (INIT_CYCLES > CORR_CYCLES) ? INIT_CYCLES : CORR_CYCLES;
    localparam int MAX_B   = (CLSF_CYCLES > INJ_CYCLES) ? CLSF_CYCLES : INJ_CYCLES;
    localparam int MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_DUR + 1);

    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] CORR_LAST = CNT_W'(CORR_CYCLES - 1);
    localparam logic [CNT_W-1:0] CLSF_LAST = CNT_W'(CLSF_CYCLES - 1);
    localparam logic [CNT_W-1:0] INJ_LAST  = CNT_W'(INJ_CYCLES - 1);

    typedef struct packed {
        scrub_state_e       state;
        logic [CNT_W-1:0]   cnt;
        logic               boot;
        logic               sc_evt;
        logic [7:0]         sc_code;
        logic               inj_req;
        logic [FRAME_W-1:0] frame;
        logic [WORD_W-1:0]  word;
        logic [BIT_W-1:0]   bitx;
        logic               corr_ok;
    } fsm_s;

    fsm_s fsm_d, fsm_q;
    logic timer_last;

    always_comb begin
        unique case (fsm_q.state)
            ST_INIT: timer_last = (fsm_q.cnt == INIT_LAST);
            ST_CORR: timer_last = (fsm_q.cnt == CORR_LAST);
            ST_CLSF: timer_last = (fsm_q.cnt == CLSF_LAST);
            ST_INJT: timer_last = (fsm_q.cnt == INJ_LAST);
            default: timer_last = 1'b0;
        endcase
    end

    assign corr_done = (fsm_q.state == ST_CORR) && timer_last;
    assign clsf_done = (fsm_q.state == ST_CLSF) && timer_last;

    always_comb begin
        fsm_d         = fsm_q;
        fsm_d.sc_evt  = 1'b0;
        fsm_d.inj_req = 1'b0;
        fsm_d.boot    = 1'b0;
        fsm_d.cnt     = fsm_q.cnt + 1'b1;

        if (fsm_q.boot) begin
            fsm_d.sc_evt  = 1'b1;
            fsm_d.sc_code = ST_INIT;
        end

        unique case (fsm_q.state)
            ST_INIT: begin
                if (timer_last) fsm_d.state = ST_OBSV;
            end
            ST_OBSV: begin
                fsm_d.cnt = '0;
                if (det_valid) begin
                    fsm_d.state   = ST_CORR;
                    fsm_d.corr_ok = det_correctable;
                end else if (cmd_hit[CMD_SLOT_IDLE]) begin
                    fsm_d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                fsm_d.cnt = '0;
                if (cmd_hit[CMD_SLOT_OBSV]) begin
                    fsm_d.state = ST_OBSV;
                end else if (cmd_hit[CMD_SLOT_INJT] && addr_ok) begin
                    fsm_d.state   = ST_INJT;
                    fsm_d.inj_req = 1'b1;
                    fsm_d.frame   = addr_frame;
                    fsm_d.word    = addr_word;
                    fsm_d.bitx    = addr_bit;
                end
            end
            ST_CORR: begin
                if (timer_last) fsm_d.state = ST_CLSF;
            end
            ST_CLSF: begin
                if (timer_last) fsm_d.state = ST_OBSV;
            end
            ST_INJT: begin
                if (timer_last) fsm_d.state = ST_IDLE;
            end
            default: fsm_d.state = ST_IDLE;
        endcase

        if (fsm_d.state != fsm_q.state) begin
            fsm_d.cnt     = '0;
            fsm_d.sc_evt  = 1'b1;
            fsm_d.sc_code = fsm_d.state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.state <= ST_INIT;
            fsm_q.boot  <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign cur_state = fsm_q.state;
    assign sc_evt    = fsm_q.sc_evt;
    assign sc_code   = fsm_q.sc_code;
    assign inj_req   = fsm_q.inj_req;
    assign inj_frame = fsm_q.frame;
    assign inj_word  = fsm_q.word;
    assign inj_bit   = fsm_q.bitx;
    assign corr_ok   = fsm_q.corr_ok;

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
    import scrub_seq_pkg::*;
#(
    parameter int INIT_CYCLES     = 4,
    parameter int CORR_CYCLES     = 3,
    parameter int CLSF_CYCLES     = 2,
    parameter int INJ_CYCLES      = 2,
    parameter int ADDR_W          = 40,
    parameter int WORDS_PER_FRAME = 93,
    parameter int DATA_W          = 32,
    localparam int BIT_W   = $clog2(DATA_W),
    localparam int WORD_W  = $clog2(WORDS_PER_FRAME),
    localparam int FRAME_W = ADDR_W - 4 - WORD_W - BIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_code,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic               det_valid,
    input  logic               det_correctable,
    output logic [7:0]         cur_state,
    output logic [4:0]         st_onehot,
    output logic               st_uncorr,
    output logic               st_essential,
    output logic               sc_evt,
    output logic [7:0]         sc_code,
    output logic               fc_evt,
    output logic [7:0]         fc_code,
    output logic               inj_req,
    output logic [FRAME_W-1:0] inj_frame,
    output logic [WORD_W-1:0]  inj_word,
    output logic [BIT_W-1:0]   inj_bit
);

    logic [NUM_CMDS-1:0] cmd_hit;
    logic                addr_ok;
    logic [FRAME_W-1:0]  addr_frame;
    logic [WORD_W-1:0]   addr_word;
    logic [BIT_W-1:0]    addr_bit;
    logic                corr_done;
    logic                clsf_done;
    logic                corr_ok;

    scrub_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_hit   (cmd_hit)
    );

    scrub_addr_split #(
        .ADDR_W          (ADDR_W),
        .WORDS_PER_FRAME (WORDS_PER_FRAME),
        .DATA_W          (DATA_W)
    ) u_split (
        .addr    (cmd_addr),
        .frame   (addr_frame),
        .word    (addr_word),
        .bit_idx (addr_bit),
        .addr_ok (addr_ok)
    );

    scrub_fsm #(
        .INIT_CYCLES (INIT_CYCLES),
        .CORR_CYCLES (CORR_CYCLES),
        .CLSF_CYCLES (CLSF_CYCLES),
        .INJ_CYCLES  (INJ_CYCLES),
        .FRAME_W     (FRAME_W),
        .WORD_W      (WORD_W),
        .BIT_W       (BIT_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_hit         (cmd_hit),
        .addr_ok         (addr_ok),
        .addr_frame      (addr_frame),
        .addr_word       (addr_word),
        .addr_bit        (addr_bit),
        .det_valid       (det_valid),
        .det_correctable (det_correctable),
        .cur_state       (cur_state),
        .sc_evt          (sc_evt),
        .sc_code         (sc_code),
        .inj_req         (inj_req),
        .inj_frame       (inj_frame),
        .inj_word        (inj_word),
        .inj_bit         (inj_bit),
        .corr_done       (corr_done),
        .clsf_done       (clsf_done),
        .corr_ok         (corr_ok)
    );

    scrub_flag_track u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .corr_done    (corr_done),
        .corr_ok      (corr_ok),
        .clsf_done    (clsf_done),
        .st_uncorr    (st_uncorr),
        .st_essential (st_essential),
        .fc_evt       (fc_evt),
        .fc_code      (fc_code)
    );

    // Status bit positions coincide with the state code bits
    assign st_onehot = cur_state[4:0];

endmodule

// File: rtl/scrub_seq_chk.sv
module scrub_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cur_state,
    input logic [4:0] st_onehot,
    input logic       st_uncorr,
    input logic       st_essential,
    input logic       sc_evt,
    input logic [7:0] sc_code,
    input logic       fc_evt,
    input logic [7:0] fc_code,
    input logic       inj_req
);

    localparam logic [7:0] C_IDLE = 8'h00;
    localparam logic [7:0] C_OBSV = 8'h02;
    localparam logic [7:0] C_CORR = 8'h04;
    localparam logic [7:0] C_CLSF = 8'h08;
    localparam logic [7:0] C_INJT = 8'h10;

    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cur_state) && (cur_state[7:5] == 3'b000) && $onehot0(st_onehot));

    assert_idle_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == C_IDLE && $past(cur_state) == C_IDLE)
            |-> ($stable(st_uncorr) && $stable(st_essential)));

    assert_inj_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req |-> (cur_state == C_INJT && $past(cur_state) == C_IDLE));

    assert_inj_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_state) == C_INJT && cur_state != C_INJT) |-> (cur_state == C_IDLE));

    assert_corr_to_clsf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_state) == C_CORR && cur_state != C_CORR) |-> (cur_state == C_CLSF && fc_evt));

    assert_fc_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fc_evt |-> (fc_code == {1'b0, st_essential, st_uncorr, 5'b0}));

    assert_clsf_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_state) == C_CLSF && cur_state != C_CLSF)
            |-> (cur_state == C_OBSV && st_essential && fc_evt));

    assert_change_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != $past(cur_state)) |-> (sc_evt && sc_code == cur_state));

endmodule

bind scrub_seq scrub_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_state    (cur_state),
    .st_onehot    (st_onehot),
    .st_uncorr    (st_uncorr),
    .st_essential (st_essential),
    .sc_evt       (sc_evt),
    .sc_code      (sc_code),
    .fc_evt       (fc_evt),
    .fc_code      (fc_code),
    .inj_req      (inj_req)
);

// File: tb/scrub_seq_bench.sv
module scrub_seq_bench;

    localparam int INIT_CYCLES = 4;
    localparam int CORR_CYCLES = 3;
    localparam int CLSF_CYCLES = 2;
    localparam int INJ_CYCLES  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [39:0] cmd_addr = '0;
    logic        det_valid = 1'b0;
    logic        det_correctable = 1'b0;
    logic [7:0]  cur_state;
    logic [4:0]  st_onehot;
    logic        st_uncorr, st_essential;
    logic        sc_evt, fc_evt, inj_req;
    logic [7:0]  sc_code, fc_code;
    logic [23:0] inj_frame;
    logic [6:0]  inj_word;
    logic [4:0]  inj_bit;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    scrub_seq u_scrub_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .det_valid(det_valid), .det_correctable(det_correctable),
        .cur_state(cur_state), .st_onehot(st_onehot), .st_uncorr(st_uncorr),
        .st_essential(st_essential), .sc_evt(sc_evt), .sc_code(sc_code),
        .fc_evt(fc_evt), .fc_code(fc_code), .inj_req(inj_req),
        .inj_frame(inj_frame), .inj_word(inj_word), .inj_bit(inj_bit)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int  m_state, m_left, m_sc_code, m_frame, m_word, m_bit;
    bit  m_boot, m_unc, m_ess, m_corr, m_sc_evt, m_fc_evt, m_inj;

    task automatic m_go(input int s, input int d);
        m_state = s; m_left = d; m_sc_evt = 1; m_sc_code = s;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 1; m_left = INIT_CYCLES; m_boot = 1;
            m_unc = 0; m_ess = 0; m_corr = 0;
            m_sc_evt = 0; m_fc_evt = 0; m_inj = 0; m_sc_code = 0;
            m_frame = 0; m_word = 0; m_bit = 0;
        end else begin
            m_sc_evt = 0; m_fc_evt = 0; m_inj = 0;
            if (m_boot) begin m_sc_evt = 1; m_sc_code = 1; m_boot = 0; end
            case (m_state)
                1: if (m_left == 1) m_go(2, 0); else m_left--;
                2: if (det_valid) begin
                       m_corr = det_correctable; m_go(4, CORR_CYCLES);
                   end else if (cmd_valid && cmd_code == "I") m_go(0, 0);
                0: if (cmd_valid && cmd_code == "O") m_go(2, 0);
                   else if (cmd_valid && cmd_code == "N" && cmd_addr[39:36] == 4'hC
                            && cmd_addr[11:5] < 93) begin
                       m_inj = 1; m_frame = int'(cmd_addr[35:12]);
                       m_word = int'(cmd_addr[11:5]); m_bit = int'(cmd_addr[4:0]);
                       m_go(16, INJ_CYCLES);
                   end
                4: if (m_left == 1) begin m_unc = !m_corr; m_fc_evt = 1; m_go(8, CLSF_CYCLES); end
                   else m_left--;
                8: if (m_left == 1) begin m_ess = 1; m_fc_evt = 1; m_go(2, 0); end
                   else m_left--;
                16: if (m_left == 1) m_go(0, 0); else m_left--;
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cur_state == 8'(m_state), "R1 state", cur_state, m_state);
            chk(st_onehot == 5'(m_state), "R1 onehot", st_onehot, m_state);
            chk(st_uncorr == m_unc, "R12 uncorr", st_uncorr, m_unc);
            chk(st_essential == m_ess, "R12 essential", st_essential, m_ess);
            chk(sc_evt == m_sc_evt, "R11 sc_evt", sc_evt, m_sc_evt);
            if (m_sc_evt) chk(sc_code == 8'(m_sc_code), "R11 sc_code", sc_code, m_sc_code);
            chk(fc_evt == m_fc_evt, "R8 fc_evt", fc_evt, m_fc_evt);
            if (m_fc_evt) chk(fc_code == {1'b0, m_ess, m_unc, 5'b0}, "R8 fc_code", fc_code,
                              {1'b0, m_ess, m_unc, 5'b0});
            chk(inj_req == m_inj, "R6 inj_req", inj_req, m_inj);
            if (m_inj) chk({inj_frame, inj_word, inj_bit} == {24'(m_frame), 7'(m_word), 5'(m_bit)},
                           "R6 fields", {inj_frame, inj_word, inj_bit},
                           {24'(m_frame), 7'(m_word), 5'(m_bit)});
        end
    end

    task automatic send(input logic [7:0] c, input logic [39:0] a);
        @(negedge clk); cmd_valid = 1; cmd_code = c; cmd_addr = a;
        @(negedge clk); cmd_valid = 0; cmd_code = 8'h00;
    endtask

    task automatic detect(input bit c, input bit with_i);
        @(negedge clk); det_valid = 1; det_correctable = c;
        if (with_i) begin cmd_valid = 1; cmd_code = "I"; end
        @(negedge clk); det_valid = 0; cmd_valid = 0; cmd_code = 8'h00;
    endtask

    task automatic wait_state(input logic [7:0] s, input int lim);
        for (int k = 0; k < lim && cur_state !== s; k++) @(negedge clk);
    endtask

    task automatic expect_state(input logic [7:0] s, input string tag);
        chk(cur_state == s, tag, cur_state, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cur_state == 8'h01, "R2 reset state", cur_state, 8'h01);
        chk({st_uncorr, st_essential} == 2'b00, "R12 reset flags", {st_uncorr, st_essential}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(sc_evt && sc_code == 8'h01, "R2 start event", {sc_evt, sc_code}, 9'h101);
        send("I", '0);                                    // R10: ignored in start-up
        expect_state(8'h01, "R10 cmd in start-up");
        wait_state(8'h02, 20);
        expect_state(8'h02, "R2 auto watch");

        send("N", 40'hC0000007A0);                        // R10: inject not valid while watching
        expect_state(8'h02, "R10 N in watch");
        send("O", '0);
        expect_state(8'h02, "R10 O in watch");

        detect(1'b1, 1'b0);
        expect_state(8'h04, "R7 enter repair");
        wait_state(8'h08, 10);
        chk(st_uncorr == 1'b0, "R8 correctable", st_uncorr, 0);
        send("I", '0);                                    // R10: ignored while grading
        wait_state(8'h02, 10);
        expect_state(8'h02, "R7 back to watch");
        chk(st_essential == 1'b1, "R9 essential", st_essential, 1);

        send("I", '0);
        expect_state(8'h00, "R3 to idle");
        chk(st_onehot == 5'b0 && st_essential, "R4 idle quiet", {st_onehot, st_essential}, 1);
        detect(1'b0, 1'b0);
        expect_state(8'h00, "R7 det in idle ignored");
        send("Z", '0);
        expect_state(8'h00, "R10 unknown code");

        send("N", 40'hB0000007A0);
        expect_state(8'h00, "R6 bad tag");
        send("N", 40'hC000000BA0);
        expect_state(8'h00, "R6 word 93");
        send("N", 40'hC0000007A0);
        chk(inj_req && inj_frame == 0 && inj_word == 61 && inj_bit == 0, "R6 word61 bit0",
            {inj_req, inj_frame, inj_word, inj_bit}, {1'b1, 24'd0, 7'd61, 5'd0});
        chk(st_onehot[4], "R5 inject status", st_onehot, 5'h10);
        wait_state(8'h00, 10);
        expect_state(8'h00, "R5 return idle");
        send("N", 40'hC1234560BF);
        chk(inj_frame == 24'h123456 && inj_word == 5 && inj_bit == 31, "R6 frame fields",
            {inj_frame, inj_word, inj_bit}, {24'h123456, 7'd5, 5'd31});
        wait_state(8'h00, 10);

        send("O", '0);
        expect_state(8'h02, "R3 to watch");
        detect(1'b0, 1'b1);
        expect_state(8'h04, "R7 detect beats cmd");
        send("I", '0);
        wait_state(8'h08, 10);
        chk(st_uncorr == 1'b1, "R8 uncorrectable", st_uncorr, 1);
        wait_state(8'h02, 10);
        send("I", '0);
        repeat (3) @(negedge clk);
        chk(st_uncorr == 1'b1, "R4 flag held in idle", st_uncorr, 1);
        send("O", '0);
        detect(1'b1, 1'b0);
        wait_state(8'h02, 20);
        chk(st_uncorr == 1'b0, "R12 flag rewritten", st_uncorr, 0);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule